// File: doc/BRIEF.md
# Multi-Bank Interrupt Status Aggregator

This block merges the interrupt summary lines of several general-purpose I/O banks with a set of other peripheral interrupt sources. It presents them to a host as one pending-status word and one interrupt line. Each I/O bank summary is shown live in the low status bits, and this block does not store it. The bank clears its own summary, and the bit follows. Each peripheral source is edge-captured into a sticky pending bit above the bank bits. The host clears that bit by writing a one to it.

A per-source enable word and a global enable bit decide whether pending work reaches the host. The interrupt line is registered. The host services the block by reading the status word until it is all zero. The line then falls, and any later work gives it a fresh rising edge. The host can therefore treat the line as edge-sensitive.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, the enable word and the global enable are zero, every peripheral pending bit is clear and `host_irq_o` is low. With all inputs low, both registers read zero.
- R2: Status bits 0 to 3 (address 0) show bank lines A to D directly in the same cycle. They are not latched and read zero once the line falls.
- R3: A rising edge on peripheral source k sets status bit 4+k on the next clock edge. The bit stays set after the source falls.
- R4: Writing address 0 clears each peripheral bit whose data bit is 1 and leaves the bits written as 0 unchanged. Written data bits 0 to 3 have no effect.
- R5: If a rising edge on a source and a clearing write to its bit land on the same clock edge, the bit stays set.
- R6: Address 1 holds the enable word. Bits 9:0 enable the matching status bit (1 = enabled) and bit 15 is the global enable. Both read back, and all other bits read 0.
- R7: One clock after the global enable is set and some enabled status bit is pending, `host_irq_o` is high. A pending bit whose enable is 0 does not raise it.
- R8: While the global enable is clear, `host_irq_o` is low one clock later, whatever is pending.
- R9: After `host_irq_o` has fallen, new pending work from either a bank line or a peripheral edge produces a fresh rising edge.
- R10: A source held high does not set its bit again after it has been cleared; only a new rising edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_irq_i | input | 4 | Summary line of each I/O bank, A in bit 0 |
| periph_irq_i | input | 6 | Peripheral interrupt sources |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 2 | Register address (0 status, 1 enable) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the addressed register |
| host_irq_o | output | 1 | Registered interrupt to the host |

## Verification
Capture of a new source edge and the host's write-one-to-clear of the same bit can land on the same clock edge. The bench provokes this by raising source 2 in the very cycle that a clear of bit 6 is written. It then reads the status word and expects bit 6 still set. In another case the same source is held high across a clear, and the bit must stay clear. Together the two cases separate edge capture from level capture.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int unsigned ADDR_W      = 2;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd1;
endpackage

// File: rtl/irqagg_pending.sv
module irqagg_pending #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } pend_state_t;

    pend_state_t st_d, st_q;
    logic [N-1:0] rise_w;

    // Edge detect per source; a fresh edge beats a clear in the same cycle.
    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise_w[i] = src_i[i] & ~st_q.prev[i];
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = src_i;
        st_d.pend = (st_q.pend & ~clr_i) | rise_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs #(
    parameter int unsigned SRC_N  = 10,
    parameter int unsigned DATA_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_i,
    input  logic [irqagg_pkg::ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]               wdata_i,
    output logic [SRC_N-1:0]                en_o,
    output logic                            gen_o
);
    localparam int unsigned GEN_BIT = DATA_W - 1;

    typedef struct packed {
        logic [SRC_N-1:0] en;
        logic             gen;
    } cfg_state_t;

    cfg_state_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i && addr_i == irqagg_pkg::ADDR_ENABLE) begin
            cfg_d.en  = wdata_i[SRC_N-1:0];
            cfg_d.gen = wdata_i[GEN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en_o  = cfg_q.en;
    assign gen_o = cfg_q.gen;
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg #(
    parameter int unsigned NUM_BANKS  = 4,
    parameter int unsigned NUM_PERIPH = 6,
    parameter int unsigned DATA_W     = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BANKS-1:0]          bank_irq_i,
    input  logic [NUM_PERIPH-1:0]         periph_irq_i,
    input  logic                          reg_wr_i,
    input  logic [irqagg_pkg::ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0]             reg_wdata_i,
    output logic [DATA_W-1:0]             reg_rdata_o,
    output logic                          host_irq_o
);
    localparam int unsigned SRC_N   = NUM_BANKS + NUM_PERIPH;
    localparam int unsigned GEN_BIT = DATA_W - 1;

    typedef struct packed {
        logic irq;
    } out_state_t;

    logic [NUM_PERIPH-1:0] pend_w;
    logic [NUM_PERIPH-1:0] clr_w;
    logic [SRC_N-1:0]      status_w;
    logic [SRC_N-1:0]      en_w;
    logic                  gen_w;
    out_state_t            out_d, out_q;

    assign clr_w = (reg_wr_i && reg_addr_i == irqagg_pkg::ADDR_STATUS)
                 ? reg_wdata_i[SRC_N-1:NUM_BANKS] : '0;

    irqagg_pending #(.N(NUM_PERIPH)) u_pending (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (periph_irq_i),
        .clr_i  (clr_w),
        .pend_o (pend_w)
    );

    irqagg_regs #(.SRC_N(SRC_N), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .en_o    (en_w),
        .gen_o   (gen_w)
    );

    assign status_w = {pend_w, bank_irq_i};

    always_comb begin
        out_d     = out_q;
        out_d.irq = gen_w && (|(status_w & en_w));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            irqagg_pkg::ADDR_STATUS: reg_rdata_o[SRC_N-1:0] = status_w;
            irqagg_pkg::ADDR_ENABLE: begin
                reg_rdata_o[SRC_N-1:0] = en_w;
                reg_rdata_o[GEN_BIT]   = gen_w;
            end
            default: reg_rdata_o = '0;
        endcase
    end

    assign host_irq_o = out_q.irq;
endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker #(
    parameter int unsigned NUM_BANKS  = 4,
    parameter int unsigned NUM_PERIPH = 6,
    parameter int unsigned DATA_W     = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [NUM_BANKS-1:0]          bank_i,
    input logic [NUM_PERIPH-1:0]         periph_i,
    input logic                          wr_i,
    input logic [irqagg_pkg::ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0]             wdata_i,
    input logic [DATA_W-1:0]             rdata_i,
    input logic                          irq_i,
    input logic [NUM_PERIPH-1:0]         pend_i,
    input logic [NUM_BANKS+NUM_PERIPH-1:0] en_i,
    input logic                          gen_i
);
    localparam int unsigned SRC_N = NUM_BANKS + NUM_PERIPH;

    logic [NUM_PERIPH-1:0] prev_c;
    logic [NUM_PERIPH-1:0] rise_c;
    logic [NUM_PERIPH-1:0] clr_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_c <= '0;
        else        prev_c <= periph_i;
    end

    assign rise_c = periph_i & ~prev_c;
    assign clr_c  = (wr_i && addr_i == irqagg_pkg::ADDR_STATUS)
                  ? wdata_i[SRC_N-1:NUM_BANKS] : '0;

    // R2
    a_r2_bank_live: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == irqagg_pkg::ADDR_STATUS) |-> (rdata_i[NUM_BANKS-1:0] == bank_i));

    // R3, R5
    a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_i & $past(rise_c)) == $past(rise_c)));

    // R4
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_i & $past(clr_c & ~rise_c)) == '0));

    // R7
    a_r7_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_i && (|({pend_i, bank_i} & en_i))) |=> irq_i);

    // R8
    a_r8_gen_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_i |=> !irq_i);
endmodule

bind irq_status_agg irqagg_checker #(
    .NUM_BANKS  (NUM_BANKS),
    .NUM_PERIPH (NUM_PERIPH),
    .DATA_W     (DATA_W)
) u_irqagg_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bank_i   (bank_irq_i),
    .periph_i (periph_irq_i),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_i  (reg_rdata_o),
    .irq_i    (host_irq_o),
    .pend_i   (pend_w),
    .en_i     (en_w),
    .gen_i    (gen_w)
);

// File: tb/tb_irq_status_agg.sv
module tb_irq_status_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bank = '0;
    logic [5:0]  periph = '0;
    logic        wr = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [15:0] val;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    irq_status_agg dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bank_irq_i   (bank),
        .periph_irq_i (periph),
        .reg_wr_i     (wr),
        .reg_addr_i   (addr),
        .reg_wdata_i  (wdata),
        .reg_rdata_o  (rdata),
        .host_irq_o   (irq)
    );

    // Monitor: pops expectations at the falling edge and compares.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                logic [15:0] act;
                e = exp_q.pop_front();
                act = e.is_irq ? {15'd0, irq} : rdata;
                checks++;
                if (act !== e.val) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", e.req, act, e.val);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic expect_rd(input logic [1:0] a, input logic [15:0] v, input string req);
        exp_t e;
        addr = a;
        e.is_irq = 1'b0; e.val = v; e.req = req;
        exp_q.push_back(e);
        @(negedge clk); #1;
    endtask

    task automatic expect_irq(input logic v, input string req);
        exp_t e;
        e.is_irq = 1'b1; e.val = {15'd0, v}; e.req = req;
        exp_q.push_back(e);
        @(negedge clk); #1;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        tick();
        wr = 1'b1; addr = a; wdata = d;
        tick();
        wr = 1'b0; wdata = '0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        expect_rd(2'd0, 16'h0000, "R1");
        expect_rd(2'd1, 16'h0000, "R1");
        expect_irq(1'b0, "R1");

        // R2 live bank bits
        tick(); bank = 4'b0101;
        expect_rd(2'd0, 16'h0005, "R2");
        tick(); bank = 4'b0000;
        expect_rd(2'd0, 16'h0000, "R2");

        // R3 edge capture, sticky after source falls
        tick(); periph = 6'b000010;
        tick(); periph = 6'b000000;
        tick();
        expect_rd(2'd0, 16'h0020, "R3");

        // R6 enable readback, R7 masked source stays quiet
        reg_write(2'd1, 16'h8000);
        tick();
        expect_irq(1'b0, "R7");
        reg_write(2'd1, 16'hFFFF);
        expect_rd(2'd1, 16'h83FF, "R6");
        tick();
        expect_irq(1'b1, "R7");

        // R8 global enable off
        reg_write(2'd1, 16'h03FF);
        tick();
        expect_irq(1'b0, "R8");

        // R4 write-one-to-clear; bank bits ignored on write
        reg_write(2'd0, 16'h000F);
        expect_rd(2'd0, 16'h0020, "R4");
        reg_write(2'd0, 16'h0020);
        expect_rd(2'd0, 16'h0000, "R4");

        // R9 fresh rising edge after drop
        reg_write(2'd1, 16'h83FF);
        tick();
        expect_irq(1'b0, "R9");
        tick(); bank = 4'b0001;
        tick();
        expect_irq(1'b1, "R9");
        tick(); bank = 4'b0000;
        tick();
        expect_irq(1'b0, "R9");
        tick(); periph = 6'b000001;
        tick();
        expect_rd(2'd0, 16'h0010, "R9");
        tick();
        expect_irq(1'b1, "R9");

        // R10 held-high source does not re-set after clear
        reg_write(2'd0, 16'h0010);
        repeat (3) tick();
        expect_rd(2'd0, 16'h0000, "R10");
        expect_irq(1'b0, "R10");

        // R5 edge and clear on the same clock edge
        tick();
        periph = 6'b000101; wr = 1'b1; addr = 2'd0; wdata = 16'h0040;
        tick();
        wr = 1'b0; wdata = '0;
        expect_rd(2'd0, 16'h0040, "R5");

        repeat (2) tick();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule